// File: doc/BRIEF.md
# Control Endpoint Setup Tripwire and Prime Tracker

This block holds the register state that device-controller software uses to receive setup packets on control endpoints and to prime endpoints for transfers. A protocol engine sends a one-cycle pulse on an endpoint's line when it has stored a setup packet in that endpoint's queue head. The block latches a per-endpoint setup flag and raises a level interrupt. It also drops a software-armed tripwire bit so that software can detect a setup that lands while it copies the setup buffer.

Software clears a setup flag by writing 1 to its bit. The clear takes effect only after a programmable delay, which models the short settling time of the real controller. A new setup on that endpoint cancels the pending clear. Priming an endpoint starts a fixed-length window. When the window ends, the endpoint's ready bit shows whether the prime succeeded. A prime fails if the descriptor was not valid, or if a setup reached that endpoint during the window.

The register bus has four word addresses, and each register is NUM_EP bits wide. The asynchronous active-low reset is released synchronously inside the block.

Top module: `ctrl_setup_trip`

## Requirements
- R1: Address 0 is the control register. Bit 0 is the tripwire and bit 1 is the setup-lockout-disable mode bit. A write stores both bits, and a read returns them, with all other bits reading 0.
- R2: A pulse on setup_stored[i] sets bit i of the setup status register (address 1) on the next clock edge.
- R3: Writing 1 to bit i of address 1 while it is set starts a delayed clear. The bit keeps reading 1 for CLR_DELAY-1 cycles after the write edge and reads 0 after CLR_DELAY edges. Bits written with 0 are unaffected.
- R4: Any setup pulse clears the tripwire bit on the next edge, and this takes priority over a control write of 1 in the same cycle.
- R5: Writing 1 to bit i of address 2 sets the prime bit and clears ready bit i of address 3. The prime bit returns to 0 exactly PRIME_CYCLES edges after the write edge. Writing 0 has no effect.
- R6: When a prime ends, ready bit i is set if desc_valid[i] is high at the completion edge and no setup reached endpoint i from the write edge through the completion edge.
- R7: A prime fails (ready bit i stays 0) when a setup reaches endpoint i inside the window or desc_valid[i] is low. Setups on other endpoints do not affect it.
- R8: irq is high exactly while at least one setup status bit is 1.
- R9: A setup pulse arriving in the same cycle as a clear write, or while a clear is pending, keeps the bit at 1 and cancels the clear.
- R10: The ready register at address 3 is read-only, and writes to it are ignored.
- R11: After reset, all registers read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | NUM_EP | Write data |
| reg_rdata | output | NUM_EP | Read data, combinational on reg_addr |
| setup_stored | input | NUM_EP | Per-endpoint setup-stored pulse |
| desc_valid | input | NUM_EP | Per-endpoint descriptor-valid level |
| irq | output | 1 | Setup interrupt, level |

## Verification
The hardest state to reach is a setup pulse that meets a clear already in progress. This can happen in the same cycle as the clear write or several cycles into the delay, and in both cases the clear must be cancelled and must not finish later. The bench lines up the write strobe and the setup pulse on one edge, then repeats the clear and injects a pulse part way into the delay. It then watches well past CLR_DELAY to confirm the bit never falls. Prime windows receive setups on the primed endpoint and on a neighbouring endpoint, so that a failure on one is shown not to spill into the other.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_SETUP = 2'd1,
    REG_PRIME = 2'd2,
    REG_READY = 2'd3
  } reg_sel_e;

  localparam int CTRL_TRIP_BIT = 0;
  localparam int CTRL_LKO_BIT  = 1;
endpackage

// File: rtl/cst_ctrl_reg.sv
module cst_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic w_trip,
  input  logic w_lko,
  input  logic setup_any,
  output logic trip_o,
  output logic lko_o
);
  logic trip_q, trip_d;
  logic lko_q, lko_d;

  always_comb begin
    trip_d = trip_q;
    lko_d  = lko_q;
    if (wr_en) begin
      trip_d = w_trip;
      lko_d  = w_lko;
    end
    if (setup_any) trip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      lko_q  <= 1'b0;
    end else begin
      trip_q <= trip_d;
      lko_q  <= lko_d;
    end
  end

  assign trip_o = trip_q;
  assign lko_o  = lko_q;

  assert_trip_hw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_any |=> !trip_o);
  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !setup_any) |=> (trip_o == $past(w_trip)) && (lko_o == $past(w_lko)));
endmodule

// File: rtl/cst_setup_cell.sv
module cst_setup_cell #(
  parameter int CLR_DELAY = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic setup_in,
  input  logic clr_req,
  output logic stat_o
);
  localparam int CW = $clog2(CLR_DELAY + 1);

  logic          stat_q, stat_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (setup_in) begin
      stat_d = 1'b1;
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        stat_d = 1'b0;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else if (clr_req && stat_q) begin
      pend_d = 1'b1;
      cnt_d  = CW'(CLR_DELAY - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign stat_o = stat_q;

  assert_setup_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_in |=> stat_o);
  assert_clear_delayed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (CLR_DELAY > 1 && clr_req && stat_q && !pend_q && !setup_in) |=> stat_o);
  assert_fall_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> ($past(pend_q) && !$past(setup_in)));
endmodule

// File: rtl/cst_prime_cell.sv
module cst_prime_cell #(
  parameter int PRIME_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prime_req,
  input  logic setup_in,
  input  logic desc_ok,
  output logic prime_o,
  output logic ready_o
);
  localparam int CW = $clog2(PRIME_CYCLES + 1);

  logic          prime_q, prime_d;
  logic          rdy_q, rdy_d;
  logic          seen_q, seen_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    prime_d = prime_q;
    rdy_d   = rdy_q;
    seen_d  = seen_q;
    cnt_d   = cnt_q;
    if (prime_q) begin
      seen_d = seen_q | setup_in;
      if (cnt_q == '0) begin
        prime_d = 1'b0;
        rdy_d   = desc_ok & ~seen_q & ~setup_in;
        seen_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else if (prime_req) begin
      prime_d = 1'b1;
      rdy_d   = 1'b0;
      seen_d  = setup_in;
      cnt_d   = CW'(PRIME_CYCLES - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= 1'b0;
      rdy_q   <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prime_q <= prime_d;
      rdy_q   <= rdy_d;
      seen_q  <= seen_d;
      cnt_q   <= cnt_d;
    end
  end

  assign prime_o = prime_q;
  assign ready_o = rdy_q;

  assert_no_ready_while_priming_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prime_o |-> !ready_o);
  assert_setup_fails_prime_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_o && setup_in) |=> !ready_o);
  assert_ready_needs_desc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(prime_o) && ready_o) |-> $past(desc_ok));
endmodule

// File: rtl/ctrl_setup_trip.sv
module ctrl_setup_trip #(
  parameter int NUM_EP       = 12,
  parameter int CLR_DELAY    = 150,
  parameter int PRIME_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [NUM_EP-1:0] reg_wdata,
  output logic [NUM_EP-1:0] reg_rdata,
  input  logic [NUM_EP-1:0] setup_stored,
  input  logic [NUM_EP-1:0] desc_valid,
  output logic              irq
);
  import cst_pkg::*;

  localparam int PAD_W = NUM_EP - 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              setup_any;
  logic              wr_ctrl, wr_setup, wr_prime;
  logic              trip, lko;
  logic [NUM_EP-1:0] setup_stat, prime_bits, ready_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign setup_any = |setup_stored;
  assign wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
  assign wr_setup  = reg_wr && (reg_addr == REG_SETUP);
  assign wr_prime  = reg_wr && (reg_addr == REG_PRIME);

  cst_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_ctrl),
    .w_trip    (reg_wdata[CTRL_TRIP_BIT]),
    .w_lko     (reg_wdata[CTRL_LKO_BIT]),
    .setup_any (setup_any),
    .trip_o    (trip),
    .lko_o     (lko)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    cst_setup_cell #(.CLR_DELAY(CLR_DELAY)) u_setup (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .setup_in (setup_stored[i]),
      .clr_req  (wr_setup && reg_wdata[i]),
      .stat_o   (setup_stat[i])
    );
    cst_prime_cell #(.PRIME_CYCLES(PRIME_CYCLES)) u_prime (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .prime_req (wr_prime && reg_wdata[i]),
      .setup_in  (setup_stored[i]),
      .desc_ok   (desc_valid[i]),
      .prime_o   (prime_bits[i]),
      .ready_o   (ready_bits[i])
    );
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL:  reg_rdata = {{PAD_W{1'b0}}, lko, trip};
      REG_SETUP: reg_rdata = setup_stat;
      REG_PRIME: reg_rdata = prime_bits;
      default:   reg_rdata = ready_bits;
    endcase
  end

  assign irq = |setup_stat;

  assert_irq_on_setup_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    setup_any |=> irq);
  assert_ready_ro_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && reg_addr == REG_READY && prime_bits == '0) |=> $stable(ready_bits));
endmodule

// File: tb/ctrl_setup_trip_tb.sv
module ctrl_setup_trip_tb;
  localparam int NUM_EP = 12;
  localparam int CLR_D  = 150;
  localparam int PRM    = 6;
  localparam int VW     = 1 + 2 + NUM_EP + NUM_EP + 8;
  localparam int NVEC   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [NUM_EP-1:0] reg_wdata = '0;
  logic [NUM_EP-1:0] reg_rdata;
  logic [NUM_EP-1:0] setup_stored = '0;
  logic [NUM_EP-1:0] desc_valid = '0;
  logic              irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ctrl_setup_trip #(.NUM_EP(NUM_EP), .CLR_DELAY(CLR_D), .PRIME_CYCLES(PRM)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .setup_stored(setup_stored),
    .desc_valid(desc_valid), .irq(irq));

  // vector fields: {is_write, addr, wdata, expected read, requirement number}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 12'h003, 12'h000, 8'd1},  // R1 set both control bits
    {1'b0, 2'd0, 12'h000, 12'h003, 8'd1},
    {1'b1, 2'd0, 12'h002, 12'h000, 8'd1},  // R1 mode bit alone
    {1'b0, 2'd0, 12'h000, 12'h002, 8'd1},
    {1'b1, 2'd0, 12'hFFC, 12'h000, 8'd1},  // R1 upper bits read 0
    {1'b0, 2'd0, 12'h000, 12'h000, 8'd1},
    {1'b1, 2'd2, 12'h000, 12'h000, 8'd5},  // R5 zero prime write
    {1'b0, 2'd2, 12'h000, 12'h000, 8'd5},
    {1'b1, 2'd3, 12'hFFF, 12'h000, 8'd10}, // R10 ready is read-only
    {1'b0, 2'd3, 12'h000, 12'h000, 8'd10},
    {1'b1, 2'd1, 12'hFFF, 12'h000, 8'd3},  // R3 clear of empty flags
    {1'b0, 2'd1, 12'h000, 12'h000, 8'd3}
  };

  task automatic check(input string req, input logic [NUM_EP-1:0] act, input logic [NUM_EP-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NUM_EP-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [NUM_EP-1:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse(input int ep);
    setup_stored = '0;
    setup_stored[ep] = 1'b1;
    @(negedge clk);
    setup_stored = '0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(4);

    // R11 reset state
    rd_check("R11 ctrl", 2'd0, '0);
    rd_check("R11 setup", 2'd1, '0);
    rd_check("R11 prime", 2'd2, '0);
    rd_check("R11 ready", 2'd3, '0);
    check("R11 irq", {11'd0, irq}, '0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][VW-1]) wr(VEC[k][VW-2 -: 2], VEC[k][2*NUM_EP+7 -: NUM_EP]);
      else rd_check($sformatf("R%0d vec%0d", VEC[k][7:0], k), VEC[k][VW-2 -: 2], VEC[k][NUM_EP+7 -: NUM_EP]);
    end

    // R2 / R8 setup sets flag and irq
    pulse(3);
    pulse(5);
    rd_check("R2 setup flags", 2'd1, 12'h028);
    check("R8 irq high", {11'd0, irq}, 12'h001);

    // R3 delayed clear of ep3, zeros leave ep5
    wr(2'd1, 12'h008);
    wait_edges(CLR_D - 1);
    rd_check("R3 still set before delay", 2'd1, 12'h028);
    wait_edges(1);
    rd_check("R3 cleared after delay", 2'd1, 12'h020);
    check("R8 irq with ep5", {11'd0, irq}, 12'h001);

    // R9 collision in same cycle
    pulse(7);
    setup_stored[7] = 1'b1;
    wr(2'd1, 12'h080);
    setup_stored = '0;
    wait_edges(CLR_D + 2);
    rd_check("R9 same-cycle setup wins", 2'd1, 12'h0A0);
    // R9 setup during pending clear
    wr(2'd1, 12'h080);
    wait_edges(3);
    pulse(7);
    wait_edges(CLR_D + 2);
    rd_check("R9 pending clear cancelled", 2'd1, 12'h0A0);

    // R4 tripwire
    wr(2'd0, 12'h001);
    rd_check("R4 armed", 2'd0, 12'h001);
    pulse(10);
    rd_check("R4 hw clear", 2'd0, 12'h000);
    setup_stored[11] = 1'b1;
    wr(2'd0, 12'h001);
    setup_stored = '0;
    rd_check("R4 setup beats write", 2'd0, 12'h000);

    // R8 irq drops only after all flags clear
    wr(2'd1, 12'hCA0);
    wait_edges(CLR_D - 1);
    check("R8 irq held during delay", {11'd0, irq}, 12'h001);
    wait_edges(1);
    rd_check("R3 all cleared", 2'd1, 12'h000);
    check("R8 irq low", {11'd0, irq}, 12'h000);

    // R5 / R6 prime success on ep2
    desc_valid = 12'h114;
    wr(2'd2, 12'h004);
    rd_check("R5 prime set", 2'd2, 12'h004);
    rd_check("R5 ready cleared", 2'd3, 12'h000);
    wait_edges(PRM - 1);
    rd_check("R5 prime held", 2'd2, 12'h004);
    wait_edges(1);
    rd_check("R5 prime done", 2'd2, 12'h000);
    rd_check("R6 ready set", 2'd3, 12'h004);
    wr(2'd2, 12'h004);
    rd_check("R5 reprime clears ready", 2'd3, 12'h000);
    wait_edges(PRM);
    rd_check("R6 ready again", 2'd3, 12'h004);

    // R7 setup on ep4 during prime
    wr(2'd2, 12'h010);
    pulse(4);
    wait_edges(PRM - 1);
    rd_check("R7 prime ended", 2'd2, 12'h000);
    rd_check("R7 setup fails prime", 2'd3, 12'h004);

    // R7 descriptor invalid on ep6
    wr(2'd2, 12'h040);
    wait_edges(PRM);
    rd_check("R7 invalid desc fails", 2'd3, 12'h004);

    // R7 setup on ep9 does not disturb ep8
    wr(2'd2, 12'h100);
    pulse(9);
    wait_edges(PRM - 1);
    rd_check("R7 other ep setup ignored", 2'd3, 12'h104);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule